// File: doc/BRIEF.md
# Port-Write Message Receive Unit

This unit takes in fixed-size maintenance port-write messages and keeps one of them in a single-entry slot for the host to read. A message is sixteen 32-bit words (64 bytes) that arrive on consecutive beats of a word input with a valid flag. When the slot is empty and the unit is enabled, the message is written into the slot word by word. When the last word lands, the unit marks the queue full and raises the queue-full interrupt flag. It then holds that message until the host issues a clear-queue command.

A message that starts while the slot is occupied is dropped and flagged as discarded. A message that starts while the unit is disabled is ignored silently. A separate error strobe records a transaction error. That error can be cleared only while the unit is disabled. One interrupt output combines the queue-full interrupt flag and the transaction error, each gated by its own enable.

The host uses a small register port with four word addresses. Address 0 is the mode register. Address 1 is the status register. Address 2 is the buffer index, and writing it selects a word of the slot. Address 3 reads back the selected slot word. Reads are combinational and writes take effect at the clock edge.

The message path is a state machine:
- `S_IDLE` waits for the first word. From there, `GO_STORE` is taken when the unit is enabled and the slot is empty, `GO_DROP` when it is enabled and the slot is full, and `GO_SKIP` when it is disabled.
- `S_STORE` writes words 1 to 15 into the slot.
- `S_DROP` consumes a discarded message.
- `S_SKIP` consumes a message that arrived while the unit was disabled.
- Each of these three states returns to `S_IDLE` on the sixteenth word (`END_MSG`).

Top module: `pw_rx_unit`

## Requirements
- R1: After reset, the mode register (address 0) and the status register (address 1) read 0, and irq is 0.
- R2: With unit enable (mode bit 0) set and the slot empty, a 16-word message is stored. The cycle after its last word, status bit 20 (queue full) and bit 4 (queue-full interrupt) read 1, and slot word k reads back at address 3 after k is written to address 2.
- R3: Writing mode bit 1 (clear queue) empties the slot. That bit always reads back as 0, and the next message is accepted and stored.
- R4: A message whose first word arrives while queue full is 1 is dropped. It sets status bit 3 (discarded) and leaves the slot contents unchanged.
- R5: A message that starts while unit enable is 0 changes neither the slot nor any status bit.
- R6: Writing 1 to status bit 4 or bit 3 clears that bit. Writing 1 to status bit 7 (transaction error) clears it only while unit enable is 0. err_strobe sets bit 7.
- R7: irq equals (status bit 4 AND mode bit 8, the queue-full interrupt enable) OR (status bit 7 AND mode bit 5, the error interrupt enable).
- R8: Status bit 2 (busy) is 1 while the words of an accepted message are being stored, and 0 otherwise.
- R9: Mode bits 20 (snoop enable), 8, 5 and 0 read back as written. All other mode bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address (0 mode, 1 status, 2 index, 3 slot data) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| msg_valid | input | 1 | Message word valid |
| msg_word | input | 32 | Message word |
| err_strobe | input | 1 | Transaction error pulse |
| irq | output | 1 | Interrupt request |

## Verification
- Register writes and message words are registered once at the edge where they are presented. Status, mode and irq therefore reflect a stimulus one cycle later.
- Read data is combinational, so it reflects the current register state within the same cycle.
- Queue full and the queue-full interrupt flag become visible the cycle after the sixteenth word. Busy is already 1 the cycle after the first word is taken.
- The bench drives every input on the falling edge and samples one falling edge after the rising edge that registers the stimulus. Each check therefore lands in the first cycle its result is due.

// File: rtl/pw_rx_pkg.sv
package pw_rx_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_STORE = 2'd1,
        S_DROP  = 2'd2,
        S_SKIP  = 2'd3
    } pw_state_t;

    localparam int MODE_SNOOP = 20;
    localparam int MODE_QIE   = 8;
    localparam int MODE_EIE   = 5;
    localparam int MODE_CQ    = 1;
    localparam int MODE_EN    = 0;

    localparam int STAT_FULL  = 20;
    localparam int STAT_TERR  = 7;
    localparam int STAT_QINT  = 4;
    localparam int STAT_DISC  = 3;
    localparam int STAT_BUSY  = 2;

    localparam logic [1:0] ADR_MODE = 2'd0;
    localparam logic [1:0] ADR_STAT = 2'd1;
    localparam logic [1:0] ADR_IDX  = 2'd2;
    localparam logic [1:0] ADR_DATA = 2'd3;
endpackage

// File: rtl/pw_rx_fsm.sv
module pw_rx_fsm
    import pw_rx_pkg::*;
#(
    parameter int WORDS = 16,
    localparam int CW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic          en_i,
    input  logic          full_i,
    output logic          wr_o,
    output logic [CW-1:0] wr_idx_o,
    output logic          done_o,
    output logic          drop_o,
    output logic          busy_o
);
    localparam logic [CW-1:0] LAST = CW'(WORDS - 1);

    pw_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          end_msg;

    assign end_msg = valid_i && (cnt_q == LAST);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_IDLE: if (valid_i) begin
                cnt_d = CW'(1);
                if (!en_i)       state_d = S_SKIP;   // GO_SKIP
                else if (full_i) state_d = S_DROP;   // GO_DROP
                else             state_d = S_STORE;  // GO_STORE
            end
            S_STORE, S_DROP, S_SKIP: if (valid_i) begin
                if (end_msg) begin
                    state_d = S_IDLE;                // END_MSG
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        wr_o     = 1'b0;
        wr_idx_o = cnt_q;
        done_o   = 1'b0;
        drop_o   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                wr_idx_o = '0;
                wr_o     = valid_i && en_i && !full_i;
                drop_o   = valid_i && en_i && full_i;
            end
            S_STORE: begin
                wr_o   = valid_i;
                done_o = end_msg;
            end
            S_DROP, S_SKIP: ;
        endcase
    end

    assign busy_o = (state_q == S_STORE);

    // R8: no store in progress while the slot is full
    assert_store_not_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STORE) |-> !full_i);
    // R5: a skipped message never writes the slot
    assert_skip_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SKIP) |-> !wr_o);
endmodule

// File: rtl/pw_rx_slot.sv
module pw_rx_slot #(
    parameter int WORDS = 16,
    parameter int DW    = 32,
    localparam int CW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [CW-1:0] wr_idx_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [CW-1:0] rd_idx_i,
    output logic [DW-1:0] rd_data_o
);
    logic [DW-1:0] mem_q [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)                                 mem_q[g] <= '0;
            else if (wr_i && (wr_idx_i == CW'(g)))      mem_q[g] <= wr_data_i;
        end
    end

    assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/pw_rx_regs.sv
module pw_rx_regs
    import pw_rx_pkg::*;
#(
    parameter int DW = 32,
    parameter int WORDS = 16,
    localparam int CW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [1:0]    addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          done_i,
    input  logic          drop_i,
    input  logic          err_i,
    input  logic          busy_i,
    output logic          en_o,
    output logic          full_o,
    output logic [CW-1:0] idx_o,
    output logic [DW-1:0] mode_o,
    output logic [DW-1:0] stat_o,
    output logic          irq_o
);
    logic snoop_q, qie_q, eie_q, en_q;
    logic full_q, terr_q, qint_q, disc_q;
    logic [CW-1:0] idx_q;
    logic mode_wr, stat_wr, cq_wr;

    assign mode_wr = we_i && (addr_i == ADR_MODE);
    assign stat_wr = we_i && (addr_i == ADR_STAT);
    assign cq_wr   = mode_wr && wdata_i[MODE_CQ];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snoop_q <= 1'b0; qie_q <= 1'b0; eie_q <= 1'b0; en_q <= 1'b0;
            full_q  <= 1'b0; terr_q <= 1'b0; qint_q <= 1'b0; disc_q <= 1'b0;
            idx_q   <= '0;
        end else begin
            if (mode_wr) begin
                snoop_q <= wdata_i[MODE_SNOOP];
                qie_q   <= wdata_i[MODE_QIE];
                eie_q   <= wdata_i[MODE_EIE];
                en_q    <= wdata_i[MODE_EN];
            end
            if (we_i && (addr_i == ADR_IDX)) idx_q <= wdata_i[CW-1:0];
            // a completing store wins over a simultaneous clear
            if (done_i)     full_q <= 1'b1;
            else if (cq_wr) full_q <= 1'b0;
            if (done_i)                             qint_q <= 1'b1;
            else if (stat_wr && wdata_i[STAT_QINT]) qint_q <= 1'b0;
            if (drop_i)                             disc_q <= 1'b1;
            else if (stat_wr && wdata_i[STAT_DISC]) disc_q <= 1'b0;
            if (err_i)                                      terr_q <= 1'b1;
            else if (stat_wr && wdata_i[STAT_TERR] && !en_q) terr_q <= 1'b0;
        end
    end

    always_comb begin
        mode_o = '0;
        mode_o[MODE_SNOOP] = snoop_q;
        mode_o[MODE_QIE]   = qie_q;
        mode_o[MODE_EIE]   = eie_q;
        mode_o[MODE_EN]    = en_q;
        stat_o = '0;
        stat_o[STAT_FULL]  = full_q;
        stat_o[STAT_TERR]  = terr_q;
        stat_o[STAT_QINT]  = qint_q;
        stat_o[STAT_DISC]  = disc_q;
        stat_o[STAT_BUSY]  = busy_i;
    end

    assign en_o   = en_q;
    assign full_o = full_q;
    assign idx_o  = idx_q;
    assign irq_o  = (qint_q && qie_q) || (terr_q && eie_q);

    // R2: queue full only rises after a completed store
    assert_full_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_q) |-> $past(done_i));
    // R3: queue full only falls after a clear-queue command
    assert_full_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_q) |-> $past(cq_wr));
    // R4: a dropped message leaves the discarded flag set
    assert_drop_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        drop_i |=> disc_q);
    // R6: transaction error survives while the unit is enabled
    assert_terr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (terr_q && en_q) |=> terr_q);
endmodule

// File: rtl/pw_rx_unit.sv
module pw_rx_unit
    import pw_rx_pkg::*;
#(
    parameter int WORDS = 16,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          msg_valid,
    input  logic [DW-1:0] msg_word,
    input  logic          err_strobe,
    output logic          irq
);
    localparam int CW = $clog2(WORDS);

    logic          en, full, wr, done, drop, busy;
    logic [CW-1:0] wr_idx, rd_idx;
    logic [DW-1:0] mode_v, stat_v, slot_v;

    pw_rx_fsm #(.WORDS(WORDS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .valid_i(msg_valid), .en_i(en), .full_i(full),
        .wr_o(wr), .wr_idx_o(wr_idx), .done_o(done), .drop_o(drop), .busy_o(busy)
    );

    pw_rx_slot #(.WORDS(WORDS), .DW(DW)) u_slot (
        .clk(clk), .rst_n(rst_n), .wr_i(wr), .wr_idx_i(wr_idx), .wr_data_i(msg_word),
        .rd_idx_i(rd_idx), .rd_data_o(slot_v)
    );

    pw_rx_regs #(.DW(DW), .WORDS(WORDS)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr), .wdata_i(reg_wdata),
        .done_i(done), .drop_i(drop), .err_i(err_strobe), .busy_i(busy),
        .en_o(en), .full_o(full), .idx_o(rd_idx), .mode_o(mode_v), .stat_o(stat_v),
        .irq_o(irq)
    );

    always_comb begin
        unique case (reg_addr)
            ADR_MODE: reg_rdata = mode_v;
            ADR_STAT: reg_rdata = stat_v;
            ADR_IDX:  reg_rdata = DW'(rd_idx);
            ADR_DATA: reg_rdata = slot_v;
        endcase
    end

    // R3: the clear-queue command bit never reads back as 1
    assert_cq_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADR_MODE) |-> !reg_rdata[MODE_CQ]);
endmodule

// File: tb/test_pw_rx_unit.sv
module test_pw_rx_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msg_valid = 1'b0;
    logic [31:0] msg_word = '0;
    logic        err_strobe = 1'b0;
    logic        irq;
    int checks = 0;
    int failures = 0;
    bit finished = 0;

    localparam logic [31:0] FULL = 32'h0010_0000, TERR = 32'h80, QINT = 32'h10,
                            DISC = 32'h08, BUSY = 32'h04;
    localparam logic [31:0] M_EN = 32'h1, M_CQ = 32'h2, M_EIE = 32'h20,
                            M_QIE = 32'h100, M_SN = 32'h0010_0000;

    always #5 clk = ~clk;

    pw_rx_unit i_pw_rx_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
        .msg_word(msg_word), .err_strobe(err_strobe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] word_of(input logic [15:0] seed, input int k);
        return {seed, 16'(k * 16'h0101 + 16'h0011)};
    endfunction

    // sends 16 words; checks busy after the third word when chk_busy
    task automatic send(input logic [15:0] seed, input bit chk_busy, input logic [31:0] busy_exp);
        logic [31:0] v;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (k == 3 && chk_busy) begin
                rd(2'd1, v);
                check("R8 busy mid-message", v & BUSY, busy_exp);
            end
            msg_valid = 1'b1; msg_word = word_of(seed, k);
        end
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic check_slot(input string req, input logic [15:0] seed);
        logic [31:0] v;
        for (int k = 0; k < 16; k++) begin
            wr(2'd2, 32'(k));
            rd(2'd3, v);
            check(req, v, word_of(seed, k));
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        rd(2'd0, v); check("R1 mode reset", v, 32'h0);
        rd(2'd1, v); check("R1 status reset", v, 32'h0);
        check("R1 irq reset", 32'(irq), 32'h0);

        // R9 / R3: writable mode bits, clear queue reads 0
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); check("R9 mode readback all ones", v, M_SN | M_QIE | M_EIE | M_EN);
        wr(2'd0, M_SN);
        rd(2'd0, v); check("R9 mode readback snoop", v, M_SN);
        wr(2'd0, 32'h0);

        // R5: disabled message ignored
        send(16'hAAAA, 1'b1, 32'h0);
        rd(2'd1, v); check("R5 status after disabled message", v, 32'h0);
        wr(2'd2, 32'd5); rd(2'd3, v); check("R5 slot untouched", v, 32'h0);

        // R2 / R8
        wr(2'd0, M_EN | M_QIE);
        send(16'hB001, 1'b1, BUSY);
        rd(2'd1, v); check("R2 full and qint after store", v, FULL | QINT);
        check("R7 irq on qint", 32'(irq), 32'h1);
        check_slot("R2 slot word", 16'hB001);

        // R4: dropped while full
        send(16'hC002, 1'b1, 32'h0);
        rd(2'd1, v); check("R4 discarded set", v, FULL | QINT | DISC);
        check_slot("R4 slot unchanged", 16'hB001);

        // R6: W1C
        wr(2'd1, QINT);
        rd(2'd1, v); check("R6 qint cleared", v, FULL | DISC);
        check("R7 irq after qint clear", 32'(irq), 32'h0);
        wr(2'd1, DISC);
        rd(2'd1, v); check("R6 discarded cleared", v, FULL);

        // R3: clear queue then accept
        wr(2'd0, M_EN | M_QIE | M_CQ);
        rd(2'd1, v); check("R3 full cleared", v, 32'h0);
        rd(2'd0, v); check("R3 cq reads 0", v, M_EN | M_QIE);
        send(16'hD003, 1'b0, 32'h0);
        rd(2'd1, v); check("R3 next message stored", v, FULL | QINT);
        check_slot("R3 new slot word", 16'hD003);

        // R6 transaction error
        wr(2'd0, M_EN | M_EIE);
        @(negedge clk); err_strobe = 1'b1;
        @(negedge clk); err_strobe = 1'b0;
        rd(2'd1, v); check("R6 err sets TE", v & TERR, TERR);
        check("R7 irq on TE", 32'(irq), 32'h1);
        wr(2'd1, TERR);
        rd(2'd1, v); check("R6 TE kept while enabled", v & TERR, TERR);
        wr(2'd0, M_EIE);
        wr(2'd1, TERR);
        rd(2'd1, v); check("R6 TE cleared while disabled", v & TERR, 32'h0);
        check("R7 irq after TE clear", 32'(irq), 32'h0);

        // R7 sweep: qint is set; set TE again
        @(negedge clk); err_strobe = 1'b1;
        @(negedge clk); err_strobe = 1'b0;
        for (int q = 0; q < 2; q++) begin
            for (int e = 0; e < 2; e++) begin
                wr(2'd0, (q != 0 ? M_QIE : 32'h0) | (e != 0 ? M_EIE : 32'h0));
                check("R7 irq sweep", 32'(irq), 32'((q != 0) || (e != 0)));
            end
        end
        wr(2'd1, QINT);
        wr(2'd0, M_QIE);
        check("R7 irq qie with qint clear", 32'(irq), 32'h0);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule